// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the slave side of a four-wire serial port (chip select, serial clock, data in, data out plus an output enable, and a pause input) that sits in front of a small byte-wide nonvolatile memory model. It runs on the system clock and registers the serial pins, so the serial clock must be several times slower than `clk`. It takes in an 8-bit command, then a 16-bit address where the command needs one, then data bytes. It turns these into single-cycle requests toward the memory side. Array storage, page handling, the write-enable latch itself and the protection policy all sit outside. The block only reports what the host asked for, and it reads back the write-enable and busy state it needs in order to filter commands.

Data is sampled on rising serial-clock edges and driven on falling edges, most significant bit first. The clock may idle low or high. A read streams bytes from consecutive addresses and wraps to address 0 after the top of the array. A status read streams the status byte again and again, so a host can poll it. The output stays in high impedance except while the block is actually driving read data.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: The command byte is decoded with its upper nibble required to be 0 and bit 3 ignored. Low bits 110 pulse `wen_set` once and low bits 100 pulse `wen_clr` once.
- R2: Input bits are taken on rising serial-clock edges and output bits change only on falling edges. Both directions are MSB first, and this works with the clock idling low or idling high.
- R3: Low bits 101 (status read) drive `sr_rd_data` on the output, and a fresh copy is sent for every further byte clocked while selected.
- R4: Low bits 011 (array read) take a 16-bit address and keep only its low `ADDR_W` bits. Bytes are then streamed from consecutive addresses, wrapping from 2^`ADDR_W`-1 to 0.
- R5: Low bits 010 (array write) with `mem_wen` high take a 16-bit address. Each later data byte then raises `wr_req` for one cycle, with `wr_data` set and `wr_addr` starting at the given address and going up by one per byte.
- R6: An array write received while `mem_wen` is low produces no `wr_req` at all.
- R7: Low bits 001 (status write) raise `sr_wr_req` for one cycle with the byte that follows as `sr_wr_data`.
- R8: An undefined command leaves the output disabled and produces no request for the rest of that selection. The next selection is decoded normally.
- R9: While `mem_busy` is high, every command other than status read is ignored.
- R10: With `spi_hold_n` taken low while the clock is low, the output is disabled and clock and data edges are ignored. Releasing it while the clock is low resumes the transfer at the same bit.
- R11: While `spi_cs_n` is high, `spi_miso_oe` is low and clock and data activity produce no request.
- R12: Every falling edge of `spi_cs_n` restarts decoding at the first bit of a command, discarding any partly received command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Active-low pause |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low means high impedance) |
| mem_busy | input | 1 | Internal write cycle in progress |
| mem_wen | input | 1 | Current write-enable latch value |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array byte at `rd_addr` (combinational) |
| wr_req | output | 1 | One-cycle array byte write request |
| wr_addr | output | ADDR_W | Address for `wr_req` |
| wr_data | output | 8 | Data for `wr_req` |
| sr_rd_data | input | 8 | Status byte to send |
| sr_wr_req | output | 1 | One-cycle status write request |
| sr_wr_data | output | 8 | Data for `sr_wr_req` |
| wen_set | output | 1 | One-cycle request to set write enable |
| wen_clr | output | 1 | One-cycle request to clear write enable |

## Verification
The assertions rely on the serial pins being synchronous to `clk` and on each serial-clock level lasting at least two system cycles, so that every edge is seen once and rising and falling edges never fall in the same cycle. They also rely on `spi_hold_n` changing only while the serial clock is low. The bench drives every pin on the falling edge of `clk`, holds each serial-clock level for four system cycles, and moves the pause input only while the clock is low, including the clock-idle-high case.

// File: rtl/eepfe_pkg.sv
package eepfe_pkg;

    // command low bits, valid only when the upper nibble is zero
    localparam logic [2:0] OPC_WEN_ON  = 3'b110;
    localparam logic [2:0] OPC_WEN_OFF = 3'b100;
    localparam logic [2:0] OPC_SR_RD   = 3'b101;
    localparam logic [2:0] OPC_SR_WR   = 3'b001;
    localparam logic [2:0] OPC_ARR_RD  = 3'b011;
    localparam logic [2:0] OPC_ARR_WR  = 3'b010;

    localparam int unsigned CMD_BITS  = 8;
    localparam int unsigned ADDR_BITS = 16;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_RDOUT,
        PH_SROUT,
        PH_SRIN,
        PH_WRDATA,
        PH_IDLE
    } phase_e;

endpackage

// File: rtl/eepfe_pin_sync.sv
module eepfe_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic hold_n_i,
    output logic sel_o,
    output logic cs_fall_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic mosi_o,
    output logic held_o
);

    typedef struct packed {
        logic cs_n;
        logic cs_prev;
        logic sck;
        logic sck_prev;
        logic mosi;
        logic hold_n;
        logic held;
    } pin_st_t;

    pin_st_t pin_d, pin_q;

    always_comb begin
        pin_d          = pin_q;
        pin_d.cs_n     = cs_n_i;
        pin_d.cs_prev  = pin_q.cs_n;
        pin_d.sck      = sck_i;
        pin_d.sck_prev = pin_q.sck;
        pin_d.mosi     = mosi_i;
        pin_d.hold_n   = hold_n_i;
        // pause state follows the pin only while the clock is low
        if (!pin_q.sck) begin
            pin_d.held = ~pin_q.hold_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '{cs_n: 1'b1, cs_prev: 1'b1, sck: 1'b0, sck_prev: 1'b0,
                       mosi: 1'b0, hold_n: 1'b1, held: 1'b0};
        end else begin
            pin_q <= pin_d;
        end
    end

    assign sel_o      = ~pin_q.cs_n;
    assign cs_fall_o  = pin_q.cs_prev & ~pin_q.cs_n;
    assign sck_rise_o = ~pin_q.cs_n & ~pin_q.held & pin_q.sck & ~pin_q.sck_prev;
    assign sck_fall_o = ~pin_q.cs_n & ~pin_q.held & ~pin_q.sck & pin_q.sck_prev;
    assign mosi_o     = pin_q.mosi;
    assign held_o     = pin_q.held;

    // R10
    held_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q.sck |=> $stable(held_o));

endmodule

// File: rtl/eepfe_cmd_engine.sv
module eepfe_cmd_engine
    import eepfe_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              cs_fall_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    input  logic              busy_i,
    input  logic              wen_i,
    input  logic [7:0]        rd_data_i,
    input  logic [7:0]        sr_data_i,
    output logic              miso_o,
    output logic              drv_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              sr_wr_req_o,
    output logic [7:0]        sr_wr_data_o,
    output logic              wen_set_o,
    output logic              wen_clr_o
);

    localparam int unsigned CNT_W     = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

    typedef struct packed {
        phase_e                 phase;
        logic                   is_wr;
        logic [CNT_W-1:0]       bitcnt;
        logic [ADDR_BITS-1:0]   shreg;
        logic [ADDR_W-1:0]      addr;
        logic [7:0]             obuf;
        logic [2:0]             ocnt;
        logic                   drv;
        logic                   miso;
        logic                   wr_req;
        logic [ADDR_W-1:0]      wr_addr;
        logic [7:0]             wr_data;
        logic                   sr_wr_req;
        logic                   wen_set;
        logic                   wen_clr;
    } eng_st_t;

    eng_st_t eng_d, eng_q;
    logic [ADDR_BITS-1:0] sh_next;
    logic [7:0]           out_byte;
    logic                 out_phase;

    always_comb begin
        eng_d           = eng_q;
        eng_d.wr_req    = 1'b0;
        eng_d.sr_wr_req = 1'b0;
        eng_d.wen_set   = 1'b0;
        eng_d.wen_clr   = 1'b0;
        sh_next   = {eng_q.shreg[ADDR_BITS-2:0], mosi_i};
        out_phase = (eng_q.phase == PH_RDOUT) || (eng_q.phase == PH_SROUT);
        out_byte  = (eng_q.phase == PH_RDOUT) ? rd_data_i : sr_data_i;

        if (!sel_i || cs_fall_i) begin
            eng_d.phase  = PH_OPC;
            eng_d.is_wr  = 1'b0;
            eng_d.bitcnt = '0;
            eng_d.ocnt   = '0;
            eng_d.drv    = 1'b0;
        end else if (sck_rise_i) begin
            case (eng_q.phase)
                PH_OPC: begin
                    eng_d.shreg  = sh_next;
                    eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                    if (eng_q.bitcnt == CMD_LAST) begin
                        eng_d.bitcnt = '0;
                        eng_d.phase  = PH_IDLE;
                        if (sh_next[7:4] == 4'h0 &&
                            (!busy_i || sh_next[2:0] == OPC_SR_RD)) begin
                            case (sh_next[2:0])
                                OPC_WEN_ON:  eng_d.wen_set = 1'b1;
                                OPC_WEN_OFF: eng_d.wen_clr = 1'b1;
                                OPC_SR_RD:   eng_d.phase   = PH_SROUT;
                                OPC_SR_WR:   eng_d.phase   = PH_SRIN;
                                OPC_ARR_RD: begin
                                    eng_d.phase = PH_ADDR;
                                    eng_d.is_wr = 1'b0;
                                end
                                OPC_ARR_WR: begin
                                    if (wen_i) begin
                                        eng_d.phase = PH_ADDR;
                                        eng_d.is_wr = 1'b1;
                                    end
                                end
                                default: eng_d.phase = PH_IDLE;
                            endcase
                        end
                    end
                end
                PH_ADDR: begin
                    eng_d.shreg  = sh_next;
                    eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                    if (eng_q.bitcnt == ADDR_LAST) begin
                        eng_d.bitcnt = '0;
                        eng_d.addr   = sh_next[ADDR_W-1:0];
                        eng_d.phase  = eng_q.is_wr ? PH_WRDATA : PH_RDOUT;
                    end
                end
                PH_SRIN, PH_WRDATA: begin
                    eng_d.shreg  = sh_next;
                    eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                    if (eng_q.bitcnt == CMD_LAST) begin
                        eng_d.bitcnt  = '0;
                        eng_d.wr_data = sh_next[7:0];
                        if (eng_q.phase == PH_SRIN) begin
                            eng_d.sr_wr_req = 1'b1;
                            eng_d.phase     = PH_IDLE;
                        end else begin
                            eng_d.wr_req  = 1'b1;
                            eng_d.wr_addr = eng_q.addr;
                            eng_d.addr    = eng_q.addr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (sck_fall_i && out_phase) begin
            if (eng_q.ocnt == 3'd0) begin
                eng_d.miso = out_byte[7];
                eng_d.obuf = {out_byte[6:0], 1'b0};
            end else begin
                eng_d.miso = eng_q.obuf[7];
                eng_d.obuf = {eng_q.obuf[6:0], 1'b0};
            end
            eng_d.ocnt = eng_q.ocnt + 1'b1;
            eng_d.drv  = 1'b1;
            if (eng_q.ocnt == 3'd7 && eng_q.phase == PH_RDOUT) begin
                eng_d.addr = eng_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign miso_o       = eng_q.miso;
    assign drv_o        = eng_q.drv;
    assign rd_addr_o    = eng_q.addr;
    assign wr_req_o     = eng_q.wr_req;
    assign wr_addr_o    = eng_q.wr_addr;
    assign wr_data_o    = eng_q.wr_data;
    assign sr_wr_req_o  = eng_q.sr_wr_req;
    assign sr_wr_data_o = eng_q.wr_data;
    assign wen_set_o    = eng_q.wen_set;
    assign wen_clr_o    = eng_q.wen_clr;

    // R2
    miso_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall_i |=> $stable(miso_o));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.phase == PH_IDLE) |-> !drv_o);

    // R1
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req_o, sr_wr_req_o, wen_set_o, wen_clr_o}));

endmodule

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              mem_busy,
    input  logic              mem_wen,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic [7:0]        sr_rd_data,
    output logic              sr_wr_req,
    output logic [7:0]        sr_wr_data,
    output logic              wen_set,
    output logic              wen_clr
);

    logic sel, cs_fall, sck_rise, sck_fall, mosi_s, held, drv;
    logic oe_d, oe_q;

    eepfe_pin_sync pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (spi_cs_n),
        .sck_i     (spi_sck),
        .mosi_i    (spi_mosi),
        .hold_n_i  (spi_hold_n),
        .sel_o     (sel),
        .cs_fall_o (cs_fall),
        .sck_rise_o(sck_rise),
        .sck_fall_o(sck_fall),
        .mosi_o    (mosi_s),
        .held_o    (held)
    );

    eepfe_cmd_engine #(.ADDR_W(ADDR_W)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .cs_fall_i   (cs_fall),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .mosi_i      (mosi_s),
        .busy_i      (mem_busy),
        .wen_i       (mem_wen),
        .rd_data_i   (rd_data),
        .sr_data_i   (sr_rd_data),
        .miso_o      (spi_miso),
        .drv_o       (drv),
        .rd_addr_o   (rd_addr),
        .wr_req_o    (wr_req),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .sr_wr_req_o (sr_wr_req),
        .sr_wr_data_o(sr_wr_data),
        .wen_set_o   (wen_set),
        .wen_clr_o   (wen_clr)
    );

    always_comb begin
        oe_d = sel & ~held & drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= oe_d;
        end
    end

    assign spi_miso_oe = oe_q;

    // R11
    oe_off_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !spi_miso_oe);

    // R10
    oe_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> !spi_miso_oe);

endmodule

// File: tb/spi_eeprom_frontend_tb.sv
module spi_eeprom_frontend_tb_top;

    localparam int AW   = 10;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, spi_hold_n = 1'b1;
    logic spi_miso, spi_miso_oe;
    logic mem_busy = 1'b0;
    logic wen_m;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data, sr_rd_data, sr_wr_data;
    logic wr_req, sr_wr_req, wen_set, wen_clr;

    logic [7:0] mem [0:(1<<AW)-1];
    int n_chk = 0, n_err = 0;
    int n_wr = 0, n_srw = 0, n_set = 0, n_clr = 0;
    logic [7:0] last_sr;
    logic m3 = 1'b0;

    always #4 clk = ~clk;

    spi_eeprom_frontend #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .mem_busy(mem_busy), .mem_wen(wen_m),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .sr_rd_data(sr_rd_data), .sr_wr_req(sr_wr_req),
        .sr_wr_data(sr_wr_data), .wen_set(wen_set), .wen_clr(wen_clr)
    );

    function automatic logic [7:0] f_init(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    assign rd_data    = mem[rd_addr];
    assign sr_rd_data = {3'b101, 3'b000, wen_m, mem_busy};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= f_init(i);
            wen_m <= 1'b0;
        end else begin
            if (wr_req) begin n_wr++; mem[wr_addr] <= wr_data; end
            if (sr_wr_req) begin n_srw++; last_sr <= sr_wr_data; end
            if (wen_set) begin n_set++; wen_m <= 1'b1; end
            if (wen_clr) begin n_clr++; wen_m <= 1'b0; end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        spi_sck = m3;
        waitc(2 * HALF);
        spi_cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic sel_off();
        waitc(HALF);
        spi_cs_n = 1'b1;
        waitc(2 * HALF);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                         output logic oe_all, output logic oe_any);
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            if (m3) spi_sck = 1'b0;
            spi_mosi = tx[i];
            waitc(HALF);
            rx[i]  = spi_miso;
            oe_all = oe_all & spi_miso_oe;
            oe_any = oe_any | spi_miso_oe;
            spi_sck = 1'b1;
            waitc(HALF);
            if (!m3) spi_sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r;
        logic a, b;
        xbyte(tx, r, a, b);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel_on();
        send(op);
        sel_off();
    endtask

    task automatic t_reset();
        chk("R11 oe after reset", int'(spi_miso_oe), 0);
        chk("R11 no request after reset", n_wr + n_srw + n_set + n_clr, 0);
    endtask

    task automatic t_wen_cmds();
        cmd1(8'h0E);
        chk("R1 set with bit3 high", n_set, 1);
        cmd1(8'h04);
        chk("R1 clear pulse", n_clr, 1);
        chk("R1 latch cleared", int'(wen_m), 0);
        cmd1(8'h06);
        chk("R1 set pulse", n_set, 2);
    endtask

    task automatic t_status_read(input logic mode);
        logic [7:0] r;
        logic a, b;
        m3 = mode;
        sel_on();
        xbyte(8'h05, r, a, b);
        chk("R3 oe low during command", int'(b), 0);
        xbyte(8'h00, r, a, b);
        chk("R3 status byte 1", r, 8'hA2);
        chk("R2 oe during status", int'(a), 1);
        xbyte(8'h00, r, a, b);
        chk("R3 status byte repeat", r, 8'hA2);
        sel_off();
        chk("R11 oe low after deselect", int'(spi_miso_oe), 0);
        m3 = 1'b0;
    endtask

    task automatic t_read_wrap();
        logic [7:0] r;
        logic a, b;
        m3 = 1'b1;
        sel_on();
        send(8'h0B);
        send(8'hFB);
        send(8'hFE);
        for (int k = 0; k < 4; k++) begin
            xbyte(8'h55, r, a, b);
            chk("R4 read stream with wrap", r, f_init((12'h3FE + k) & 12'h3FF));
            chk("R2 oe on during read", int'(a), 1);
        end
        sel_off();
        m3 = 1'b0;
    endtask

    task automatic t_write();
        logic [7:0] r;
        logic a, b;
        int w0;
        cmd1(8'h06);
        w0 = n_wr;
        sel_on();
        xbyte(8'h02, r, a, b);
        send(8'h01);
        send(8'h23);
        xbyte(8'h5A, r, a, b);
        xbyte(8'hC3, r, a, b);
        chk("R5 oe stays low in write", int'(b), 0);
        sel_off();
        chk("R5 two write requests", n_wr - w0, 2);
        chk("R5 first byte", mem[10'h123], 8'h5A);
        chk("R5 second byte next address", mem[10'h124], 8'hC3);
    endtask

    task automatic t_write_blocked();
        int w0;
        cmd1(8'h04);
        w0 = n_wr;
        sel_on();
        send(8'h02);
        send(8'h00);
        send(8'h40);
        send(8'h99);
        sel_off();
        chk("R6 no write when disabled", n_wr - w0, 0);
        chk("R6 cell untouched", mem[10'h040], f_init(10'h040));
    endtask

    task automatic t_status_write();
        int s0;
        s0 = n_srw;
        sel_on();
        send(8'h09);
        send(8'h8C);
        sel_off();
        chk("R7 status write count", n_srw - s0, 1);
        chk("R7 status write data", last_sr, 8'h8C);
    endtask

    task automatic t_invalid();
        logic [7:0] r;
        logic a, b;
        int s0;
        s0 = n_set;
        sel_on();
        xbyte(8'h13, r, a, b);
        xbyte(8'h00, r, a, b);
        chk("R8 oe stays low", int'(b), 0);
        send(8'h06);
        sel_off();
        chk("R8 later bytes ignored", n_set - s0, 0);
        cmd1(8'h06);
        chk("R8 next selection decoded", n_set - s0, 1);
    endtask

    task automatic t_busy();
        logic [7:0] r;
        logic a, b;
        int s0;
        cmd1(8'h04);
        mem_busy = 1'b1;
        s0 = n_set;
        cmd1(8'h06);
        chk("R9 set ignored while busy", n_set - s0, 0);
        sel_on();
        send(8'h03);
        send(8'h00);
        xbyte(8'h00, r, a, b);
        xbyte(8'h00, r, a, b);
        chk("R9 read ignored while busy", int'(b), 0);
        sel_off();
        sel_on();
        send(8'h05);
        xbyte(8'h00, r, a, b);
        chk("R9 status read while busy", r, 8'hA1);
        sel_off();
        mem_busy = 1'b0;
    endtask

    task automatic t_hold();
        logic [7:0] r;
        logic a, b;
        sel_on();
        send(8'h03);
        send(8'h00);
        spi_hold_n = 1'b0;
        waitc(HALF);
        for (int k = 0; k < 3; k++) begin
            spi_mosi = 1'b1;
            spi_sck = 1'b1;
            waitc(HALF);
            spi_sck = 1'b0;
            waitc(HALF);
        end
        spi_hold_n = 1'b1;
        waitc(HALF);
        send(8'h10);
        xbyte(8'h00, r, a, b);
        chk("R10 address kept across pause", r, f_init(10'h010));
        spi_hold_n = 1'b0;
        waitc(HALF);
        chk("R10 oe low while paused", int'(spi_miso_oe), 0);
        for (int k = 0; k < 2; k++) begin
            spi_sck = 1'b1;
            waitc(HALF);
            spi_sck = 1'b0;
            waitc(HALF);
        end
        spi_hold_n = 1'b1;
        waitc(HALF);
        chk("R10 oe back after release", int'(spi_miso_oe), 1);
        xbyte(8'h00, r, a, b);
        chk("R10 stream resumes", r, f_init(10'h011));
        sel_off();
    endtask

    task automatic t_deselected();
        int s0;
        s0 = n_set + n_clr + n_wr + n_srw;
        for (int k = 0; k < 16; k++) begin
            spi_mosi = k[1] ^ k[2];
            spi_sck = 1'b1;
            waitc(HALF);
            spi_sck = 1'b0;
            waitc(HALF);
        end
        chk("R11 no request while deselected", n_set + n_clr + n_wr + n_srw - s0, 0);
        chk("R11 oe low while deselected", int'(spi_miso_oe), 0);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic a, b;
        int s0;
        cmd1(8'h04);
        s0 = n_set;
        sel_on();
        for (int k = 0; k < 5; k++) begin
            spi_mosi = k[0];
            waitc(HALF);
            spi_sck = 1'b1;
            waitc(HALF);
            spi_sck = 1'b0;
        end
        sel_off();
        cmd1(8'h06);
        chk("R12 fresh decode after abort", n_set - s0, 1);
        sel_on();
        send(8'h05);
        xbyte(8'h00, r, a, b);
        sel_off();
        chk("R12 status after abort", r, 8'hA2);
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_wen_cmds();
        t_status_read(1'b0);
        t_status_read(1'b1);
        t_read_wrap();
        t_write();
        t_write_blocked();
        t_status_write();
        t_invalid();
        t_busy();
        t_hold();
        t_deselected();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule